// File: doc/BRIEF.md
# Programmable Truth-Table Bitwise Logic Unit

This unit computes a 64-bit result in which every bit is produced by the same small truth table, applied independently at each bit position. It replaces a set of fixed logic operators (AND, OR, XOR, select and so on) with a single datapath whose function is chosen by table contents.

Two modes exist. The three-input mode takes the destination's previous contents, a first source and a second source, and looks up an 8-bit immediate at each bit position. The two-input mode takes the two sources only. Its 4-entry table is one nibble of an 8-bit table operand, and a select input picks that nibble.

When recording is enabled, the unit also returns a 4-bit condition field that classifies the result as a signed number against zero. The result, the condition field and a valid flag are registered, so each operation takes one cycle.

Top module: `tlu_lut_logic`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `result` and `cond` become zero on that edge.
- R2: In three-input mode (`mode`=0), `result[i]` equals `tern_imm[k]` with k = `op_c[i]`*4 + `op_a[i]`*2 + `op_b[i]`, for every bit i.
- R3: In three-input mode, a table of 0xFF yields all ones and a table of 0x00 yields all zeros, whatever the operands are.
- R4: In two-input mode (`mode`=1) with `nib_sel`=1, the table is `bin_tbl[7:4]`, and `result[i]` equals `bin_tbl[4 + op_a[i]*2 + op_b[i]]`.
- R5: In two-input mode with `nib_sel`=0, the table is `bin_tbl[3:0]`, and `result[i]` equals `bin_tbl[op_a[i]*2 + op_b[i]]`.
- R6: In two-input mode, `op_c` and `tern_imm` have no effect on `result`.
- R7: With `rec_en`=1, `cond` compares the result as a signed 64-bit value with zero: bit 3 set when negative, bit 2 set when positive, bit 1 set when zero, bit 0 always 0. Exactly one bit is set.
- R8: With `rec_en`=0, `cond` is 4'b0000.
- R9: `out_valid` is `in_valid` delayed by one clock. `result` and `cond` update only on an edge where `in_valid` is 1, and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 1 | 0 = three-input table, 1 = two-input table |
| op_c | input | 64 | Prior destination value (index bit 2, three-input mode only) |
| op_a | input | 64 | First source (index bit 1) |
| op_b | input | 64 | Second source (index bit 0) |
| tern_imm | input | 8 | Three-input truth table |
| bin_tbl | input | 8 | Two-input table operand (two nibbles) |
| nib_sel | input | 1 | 1 = upper nibble, 0 = lower nibble |
| rec_en | input | 1 | Produce the condition field |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Registered logic result |
| cond | output | 4 | Registered condition field |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath and an 8-entry table. At that width the sign bit sits at bit 63, so the negative, positive and zero outcomes of the condition field are all reachable with full-width patterns. Both nibbles of the two-input table can be chosen, and operands with their top bit set exercise the signed comparison.

// File: rtl/lut_logic_pkg.sv
// Package: shared types and constants for the truth-table logic unit.
// Assumes an 8-entry table addressed by three operand bits.
package lut_logic_pkg;
    typedef enum logic {
        MODE_TERN = 1'b0,
        MODE_BIN  = 1'b1
    } lut_mode_e;

    localparam int COND_W   = 4;
    localparam int COND_LT  = 3;
    localparam int COND_GT  = 2;
    localparam int COND_EQ  = 1;
endpackage

// File: rtl/lut_table_sel.sv
// Builds the effective 8-entry table. In three-input mode it passes the
// immediate. In two-input mode it repeats the chosen nibble into both halves,
// so the third index bit has no effect. Assumes TBL_W is even.
module lut_table_sel
    import lut_logic_pkg::*;
#(
    parameter int TBL_W = 8
) (
    input  lut_mode_e          mode,
    input  logic [TBL_W-1:0]   tern_imm,
    input  logic [TBL_W-1:0]   bin_tbl,
    input  logic               nib_sel,
    output logic [TBL_W-1:0]   tbl_eff
);
    localparam int HALF = TBL_W / 2;

    logic [HALF-1:0] nib;

    // choose the two-input half-table and form the effective table
    always_comb begin
        nib = nib_sel ? bin_tbl[TBL_W-1:HALF] : bin_tbl[HALF-1:0];
        if (mode == MODE_BIN) tbl_eff = {nib, nib};
        else                  tbl_eff = tern_imm;
    end
endmodule

// File: rtl/lut_bit_array.sv
// One table lookup per bit position. The index is {c, a, b}, with c as the
// most significant bit. The lookups are purely combinational.
module lut_bit_array #(
    parameter int W     = 64,
    parameter int TBL_W = 8
) (
    input  logic [W-1:0]     c,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [TBL_W-1:0] tbl,
    output logic [W-1:0]     y
);
    localparam int IDX_W = $clog2(TBL_W);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [IDX_W-1:0] idx;
        // form the lookup index for this position and read the table
        always_comb begin
            idx  = {c[i], a[i], b[i]};
            y[i] = tbl[idx];
        end
    end
endmodule

// File: rtl/lut_cond_gen.sv
// Condition field from a signed compare of the value against zero.
// Returns all zeros when recording is off.
module lut_cond_gen
    import lut_logic_pkg::*;
#(
    parameter int W = 64
) (
    input  logic              rec_en,
    input  logic [W-1:0]      val,
    output logic [COND_W-1:0] cond
);
    // classify the value as negative, positive or zero
    always_comb begin
        cond = '0;
        if (rec_en) begin
            if (val[W-1])          cond[COND_LT] = 1'b1;
            else if (val == '0)    cond[COND_EQ] = 1'b1;
            else                   cond[COND_GT] = 1'b1;
        end
    end
endmodule

// File: rtl/tlu_lut_logic.sv
// Top level of the truth-table logic unit. It selects the table, evaluates
// every bit, forms the condition field and registers all outputs. Latency is
// one cycle, and the outputs hold while no operation is issued.
// Reset is synchronous and active low.
module tlu_lut_logic
    import lut_logic_pkg::*;
#(
    parameter int W     = 64,
    parameter int TBL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [W-1:0]      op_c,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [TBL_W-1:0]  tern_imm,
    input  logic [TBL_W-1:0]  bin_tbl,
    input  logic              nib_sel,
    input  logic              rec_en,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic [COND_W-1:0] cond
);
    logic [TBL_W-1:0]  tbl_eff;
    logic [W-1:0]      res_nxt;
    logic [COND_W-1:0] cond_nxt;

    lut_table_sel #(.TBL_W(TBL_W)) u_tsel (
        .mode     (lut_mode_e'(mode)),
        .tern_imm (tern_imm),
        .bin_tbl  (bin_tbl),
        .nib_sel  (nib_sel),
        .tbl_eff  (tbl_eff)
    );

    lut_bit_array #(.W(W), .TBL_W(TBL_W)) u_bits (
        .c   (op_c),
        .a   (op_a),
        .b   (op_b),
        .tbl (tbl_eff),
        .y   (res_nxt)
    );

    lut_cond_gen #(.W(W)) u_cond (
        .rec_en (rec_en),
        .val    (res_nxt),
        .cond   (cond_nxt)
    );

    // delay the valid flag by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // capture the result and condition field on an issued operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            cond   <= '0;
        end else if (in_valid) begin
            result <= res_nxt;
            cond   <= cond_nxt;
        end
    end
endmodule

// File: rtl/tlu_lut_logic_chk.sv
// Checker for tlu_lut_logic: temporal properties between its ports.
// It is attached to every instance through the bind at the end of this file.
module tlu_lut_logic_chk #(
    parameter int W     = 64,
    parameter int TBL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode,
    input logic [W-1:0]     op_c,
    input logic [W-1:0]     op_a,
    input logic [W-1:0]     op_b,
    input logic [TBL_W-1:0] tern_imm,
    input logic             rec_en,
    input logic             out_valid,
    input logic [W-1:0]     result,
    input logic [3:0]       cond
);
    // R9
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(result) && $stable(cond)));

    // R7
    cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(rec_en)) |->
            (($countones(cond) == 1) && !cond[0]));

    // R7
    cond_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(rec_en)) |->
            (cond[3] == result[W-1]));

    // R8
    cond_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(rec_en)) |-> (cond == 4'b0000));

    // R3
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(mode) && ($past(tern_imm) == 8'hFF))
            |-> (result == {W{1'b1}}));

    // R2
    tern_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(mode)) |->
            (result[0] == $past(tern_imm[{op_c[0], op_a[0], op_b[0]}])));
endmodule

bind tlu_lut_logic tlu_lut_logic_chk #(.W(W), .TBL_W(TBL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .op_c      (op_c),
    .op_a      (op_a),
    .op_b      (op_b),
    .tern_imm  (tern_imm),
    .rec_en    (rec_en),
    .out_valid (out_valid),
    .result    (result),
    .cond      (cond)
);

// File: tb/tb_tlu_lut_logic.sv
// Self-checking bench. A vector table walked by one loop, then directed tests.
module tb_tlu_lut_logic;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          mode;
    logic [W-1:0]  op_c, op_a, op_b;
    logic [7:0]    tern_imm, bin_tbl;
    logic          nib_sel, rec_en;
    logic          out_valid;
    logic [W-1:0]  result;
    logic [3:0]    cond;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tlu_lut_logic dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .op_c(op_c), .op_a(op_a), .op_b(op_b), .tern_imm(tern_imm),
        .bin_tbl(bin_tbl), .nib_sel(nib_sel), .rec_en(rec_en),
        .out_valid(out_valid), .result(result), .cond(cond)
    );

    typedef struct packed {
        logic         md;
        logic [63:0]  c;
        logic [63:0]  a;
        logic [63:0]  b;
        logic [7:0]   imm;
        logic [7:0]   tbl;
        logic         sel;
        logic         rec;
        logic [63:0]  exp_res;
        logic [3:0]   exp_cond;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R2: three-way AND
        '{1'b0, 64'h8000_0000_FFFF_0000, 64'h8000_0000_FF00_FF00, 64'h8000_0000_F0F0_F0F0,
          8'h80, 8'h00, 1'b0, 1'b1, 64'h8000_0000_F000_0000, 4'b1000},
        // R2: three-way XOR, no record (R8)
        '{1'b0, 64'h8000_0000_FFFF_0000, 64'h8000_0000_FF00_FF00, 64'h8000_0000_F0F0_F0F0,
          8'h96, 8'h00, 1'b0, 1'b0, 64'h8000_0000_F00F_0FF0, 4'b0000},
        // R3: all-ones table on zero operands
        '{1'b0, 64'h0, 64'h0, 64'h0, 8'hFF, 8'h00, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000},
        // R3: all-zeros table on all-ones operands
        '{1'b0, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, 8'h00, 8'h00, 1'b0, 1'b1, 64'h0, 4'b0010},
        // R4 R6: upper nibble 0x6 = XOR, op_c and tern_imm junk
        '{1'b1, {64{1'b1}}, 64'h0F0F, 64'h00FF, 8'hFF, 8'h6A, 1'b1, 1'b1, 64'h0FF0, 4'b0100},
        // R5: lower nibble 0xA = copy of op_b
        '{1'b1, {64{1'b1}}, 64'h0F0F, 64'h00FF, 8'h00, 8'h6A, 1'b0, 1'b1, 64'h00FF, 4'b0100},
        // R5: lower nibble 0x8 = AND
        '{1'b1, 64'h0, {64{1'b1}}, 64'h8000_0000_0000_0000, 8'h5A, 8'h08, 1'b0, 1'b1,
          64'h8000_0000_0000_0000, 4'b1000},
        // R2: table 0xF0 copies op_c
        '{1'b0, 64'h1234_5678_9ABC_DEF0, 64'h5555, 64'hAAAA, 8'hF0, 8'h00, 1'b0, 1'b1,
          64'h1234_5678_9ABC_DEF0, 4'b0100},
        // R2: table 0xCC copies op_a
        '{1'b0, 64'hFFFF, 64'h0123_4567_89AB_CDEF, 64'h3333, 8'hCC, 8'h00, 1'b0, 1'b0,
          64'h0123_4567_89AB_CDEF, 4'b0000},
        // R2 R7: table 0xAA copies op_b = 0 -> zero
        '{1'b0, {64{1'b1}}, {64{1'b1}}, 64'h0, 8'hAA, 8'h00, 1'b0, 1'b1, 64'h0, 4'b0010}
    };

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        mode = v.md; op_c = v.c; op_a = v.a; op_b = v.b;
        tern_imm = v.imm; bin_tbl = v.tbl; nib_sel = v.sel; rec_en = v.rec;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk64("R1 valid", {63'b0, out_valid}, 64'h0);
        chk64("R1 result", result, 64'h0);
        chk64("R1 cond", {60'b0, cond}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk64($sformatf("R9 valid vec%0d", i), {63'b0, out_valid}, 64'h1);
            chk64($sformatf("R2-5 result vec%0d", i), result, VECS[i].exp_res);
            chk64($sformatf("R7 R8 cond vec%0d", i), {60'b0, cond}, {60'b0, VECS[i].exp_cond});
        end

        // R9: idle cycle, outputs hold while inputs change
        drive(VECS[3]);
        @(negedge clk);
        chk64("R9 idle valid", {63'b0, out_valid}, 64'h0);
        chk64("R9 hold result", result, VECS[NV-1].exp_res);
        chk64("R9 hold cond", {60'b0, cond}, {60'b0, VECS[NV-1].exp_cond});

        // R3: all ones with mixed operands
        mode = 1'b0; tern_imm = 8'hFF; rec_en = 1'b0;
        op_c = 64'h0123_4567_89AB_CDEF; op_a = 64'hDEAD_BEEF_0000_1111; op_b = 64'h5A5A_A5A5_0F0F_F0F0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk64("R3 ones mixed", result, {64{1'b1}});
        chk64("R8 cond off", {60'b0, cond}, 64'h0);

        // R6: two-input result independent of op_c changes
        mode = 1'b1; bin_tbl = 8'hE1; nib_sel = 1'b1; rec_en = 1'b1;
        op_a = 64'h00F0; op_b = 64'h0F00; op_c = 64'h0; tern_imm = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        // upper nibble 0xE = OR: 0x0FF0, positive
        chk64("R6 R4 or c=0", result, 64'h0FF0);
        op_c = {64{1'b1}}; tern_imm = 8'h3C;
        @(negedge clk);
        in_valid = 1'b0;
        chk64("R6 or c=1", result, 64'h0FF0);
        chk64("R7 positive", {60'b0, cond}, 64'h4);

        // R1: reset mid-stream clears outputs
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk64("R1 reset result", result, 64'h0);
        chk64("R1 reset valid", {63'b0, out_valid}, 64'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule